// File: doc/BRIEF.md
# Single-Wire Identity ROM Reader

This block is a clocked master for an open-drain single-wire bus that has one serial-number device attached. A one-cycle start request makes it run one complete transaction. It holds the bus low as a reset pulse, then looks for the device's presence answer. If the device answers, the block sends an 8-bit command in timed write slots. It then reads 64 bits in timed read slots and splits them into a family byte, a 48-bit serial field and a check byte.

The bus is modelled as two pins. A registered drive-low enable controls an external open-drain driver. The level seen on the line comes back on a separate input, which passes through a two-flop synchronizer. All timing is counted in clock cycles from one parameter, `CLKS_PER_US`, which gives the number of clocks per microsecond. Every interval is loaded into a single shared down-counter.

All pins are plain control and status pins; there is no valid/ready interface and no back-pressure. The result registers change only when a transaction completes. They then hold their value until the next completion, so a consumer can read them at any later time.

Top module: `owire_rom_master`

## Requirements
- R1: After reset the block is idle. The bus is released, `busy_o`, `done_o` and `no_presence_o` are low, and all three result fields are zero.
- R2: A start pulse while idle raises `busy_o` on the next clock edge. The block latches `cmd_i` in that cycle and drives the bus low for exactly 480 µs (480·`CLKS_PER_US` cycles).
- R3: 70 µs after the reset pulse is released, the synchronized line is sampled. A low level counts as presence. A high level ends the transaction with `no_presence_o` = 1 and a `done_o` pulse; no slots follow and the result fields keep their previous values.
- R4: When presence is seen, the block waits until 480 µs after the release. It then writes the latched command, least significant bit first. A 0 bit holds the line low for 60 µs and a 1 bit for 2 µs. Every slot, write or read, starts with the master pulling the bus low, and successive slot starts are exactly 65 µs apart.
- R5: 64 read slots follow the command. Each holds the bus low for 2 µs, samples the line 12 µs after the slot start and stores the bit least significant first. Bits 0–7 form `family_o`, bits 8–55 form `serial_o` and bits 56–63 form `check_o`.
- R6: At the end of a transaction `done_o` is high for exactly one cycle, and `busy_o` is already low in that cycle. After a presence-answered transaction `no_presence_o` is 0. The results do not change until the next completion.
- R7: A start pulse while `busy_o` is high is ignored, and so is any change of `cmd_i`. The running transaction is unchanged, and exactly one `done_o` pulse results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to run a transaction |
| cmd_i | input | 8 | Command byte, latched when start is accepted |
| bus_in_i | input | 1 | Sampled level of the bus line |
| bus_drive_low_o | output | 1 | High to pull the bus low |
| busy_o | output | 1 | A transaction is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| no_presence_o | output | 1 | The last transaction saw no presence answer |
| family_o | output | 8 | Family byte (read bits 0–7) |
| serial_o | output | 48 | Serial field (read bits 8–55) |
| check_o | output | 8 | Check byte (read bits 56–63) |

## Verification
The completion pulse and the acceptance of a new start can fall in the same cycle: the cycle that raises `done_o` is also the first idle cycle. The bench provokes this by asserting `start_i` on the very cycle it first sees `done_o`, with a different command and device word. It judges the case in two ways. The first transaction's results must still be present after the second has begun. The second transaction must then deliver its own command to the device model, with a correct reset length and slot spacing.

// File: rtl/owire_pkg.sv
package owire_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RST_LOW,
    ST_PRES_WAIT,
    ST_RST_REC,
    ST_WR_LOW,
    ST_WR_REC,
    ST_RD_LOW,
    ST_RD_WAIT,
    ST_RD_REC
  } ow_state_t;

  // Bus timing in microseconds.
  localparam int unsigned T_RST_LOW_US   = 480;
  localparam int unsigned T_PRES_US      = 70;
  localparam int unsigned T_RST_REC_US   = 410;
  localparam int unsigned T_SLOT_US      = 65;
  localparam int unsigned T_W0_LOW_US    = 60;
  localparam int unsigned T_W1_LOW_US    = 2;
  localparam int unsigned T_RD_LOW_US    = 2;
  localparam int unsigned T_RD_SAMPLE_US = 12;

endpackage

// File: rtl/owire_sync.sv
module owire_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  // The line idles high, so the chain resets to ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/owire_timer.sv
module owire_timer #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load_i)     cnt_q <= val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R4: an expired timer stays expired until it is reloaded.
  a_r4_timer_rest: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_o && !load_i) |=> zero_o);
endmodule

// File: rtl/owire_rx_shift.sv
module owire_rx_shift #(
  parameter int unsigned NBITS = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [NBITS-1:0] word_o
);
  logic [NBITS-1:0] word_q;

  // Bits arrive least significant first: each new bit enters at the top.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (clr_i)   word_q <= '0;
    else if (shift_i) word_q <= {bit_i, word_q[NBITS-1:1]};
  end

  assign word_o = word_q;

  // R5: a captured bit lands in the top position.
  a_r5_shift_top: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !clr_i) |=> (word_o[NBITS-1] == $past(bit_i)));
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (word_o == '0));
endmodule

// File: rtl/owire_rom_master.sv
module owire_rom_master
  import owire_pkg::*;
#(
  parameter int unsigned CLKS_PER_US = 50,
  parameter int unsigned CMD_W       = 8,
  parameter int unsigned FAM_W       = 8,
  parameter int unsigned SER_W       = 48,
  parameter int unsigned CHK_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             bus_in_i,
  output logic             bus_drive_low_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             no_presence_o,
  output logic [FAM_W-1:0] family_o,
  output logic [SER_W-1:0] serial_o,
  output logic [CHK_W-1:0] check_o
);
  localparam int unsigned ROM_W = FAM_W + SER_W + CHK_W;
  localparam int unsigned CW    = $clog2(T_RST_LOW_US * CLKS_PER_US + 1);
  localparam int unsigned BCW   = $clog2(ROM_W);
  localparam int unsigned RW    = CW + 1;

  function automatic logic [CW-1:0] us2cyc(input int unsigned us);
    return CW'(us * CLKS_PER_US - 1);
  endfunction

  function automatic logic [CW-1:0] wr_low(input logic b);
    return b ? us2cyc(T_W1_LOW_US) : us2cyc(T_W0_LOW_US);
  endfunction

  function automatic logic [CW-1:0] wr_rec(input logic b);
    return b ? us2cyc(T_SLOT_US - T_W1_LOW_US) : us2cyc(T_SLOT_US - T_W0_LOW_US);
  endfunction

  ow_state_t        state_q, nxt;
  logic [CMD_W-1:0] cmd_q;
  logic [BCW-1:0]   bit_cnt_q;
  logic             bus_s, tmr_zero;
  logic             tmr_load;
  logic [CW-1:0]    tmr_val;
  logic             rx_clr, rx_shift, cmd_shift, bit_inc, bit_clr;
  logic             fin, miss;
  logic             drv_q, done_q, np_q;
  logic [ROM_W-1:0] rx_word;
  logic [FAM_W-1:0] fam_q;
  logic [SER_W-1:0] ser_q;
  logic [CHK_W-1:0] chk_q;

  owire_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(bus_in_i), .q_o(bus_s)
  );

  owire_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .val_i(tmr_val), .zero_o(tmr_zero)
  );

  owire_rx_shift #(.NBITS(ROM_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr_i(rx_clr), .shift_i(rx_shift),
    .bit_i(bus_s), .word_o(rx_word)
  );

  always_comb begin
    nxt       = state_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    rx_clr    = 1'b0;
    rx_shift  = 1'b0;
    cmd_shift = 1'b0;
    bit_inc   = 1'b0;
    bit_clr   = 1'b0;
    fin       = 1'b0;
    miss      = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        nxt = ST_RST_LOW; tmr_load = 1'b1; tmr_val = us2cyc(T_RST_LOW_US);
        rx_clr = 1'b1;
      end
      ST_RST_LOW: if (tmr_zero) begin
        nxt = ST_PRES_WAIT; tmr_load = 1'b1; tmr_val = us2cyc(T_PRES_US);
      end
      ST_PRES_WAIT: if (tmr_zero) begin
        if (!bus_s) begin
          nxt = ST_RST_REC; tmr_load = 1'b1; tmr_val = us2cyc(T_RST_REC_US);
        end else begin
          nxt = ST_IDLE; fin = 1'b1; miss = 1'b1;
        end
      end
      ST_RST_REC: if (tmr_zero) begin
        nxt = ST_WR_LOW; tmr_load = 1'b1; tmr_val = wr_low(cmd_q[0]); bit_clr = 1'b1;
      end
      ST_WR_LOW: if (tmr_zero) begin
        nxt = ST_WR_REC; tmr_load = 1'b1; tmr_val = wr_rec(cmd_q[0]);
      end
      ST_WR_REC: if (tmr_zero) begin
        cmd_shift = 1'b1; tmr_load = 1'b1;
        if (bit_cnt_q == BCW'(CMD_W - 1)) begin
          nxt = ST_RD_LOW; bit_clr = 1'b1; tmr_val = us2cyc(T_RD_LOW_US);
        end else begin
          nxt = ST_WR_LOW; bit_inc = 1'b1; tmr_val = wr_low(cmd_q[1]);
        end
      end
      ST_RD_LOW: if (tmr_zero) begin
        nxt = ST_RD_WAIT; tmr_load = 1'b1;
        tmr_val = us2cyc(T_RD_SAMPLE_US - T_RD_LOW_US);
      end
      ST_RD_WAIT: if (tmr_zero) begin
        nxt = ST_RD_REC; rx_shift = 1'b1; tmr_load = 1'b1;
        tmr_val = us2cyc(T_SLOT_US - T_RD_SAMPLE_US);
      end
      ST_RD_REC: if (tmr_zero) begin
        if (bit_cnt_q == BCW'(ROM_W - 1)) begin
          nxt = ST_IDLE; fin = 1'b1;
        end else begin
          nxt = ST_RD_LOW; bit_inc = 1'b1; tmr_load = 1'b1; tmr_val = us2cyc(T_RD_LOW_US);
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cmd_q     <= '0;
      bit_cnt_q <= '0;
      drv_q     <= 1'b0;
      done_q    <= 1'b0;
      np_q      <= 1'b0;
      fam_q     <= '0;
      ser_q     <= '0;
      chk_q     <= '0;
    end else begin
      state_q <= nxt;
      drv_q   <= (nxt == ST_RST_LOW) || (nxt == ST_WR_LOW) || (nxt == ST_RD_LOW);
      done_q  <= fin;
      if (state_q == ST_IDLE && start_i) cmd_q <= cmd_i;
      else if (cmd_shift)                cmd_q <= cmd_q >> 1;
      if (bit_clr)      bit_cnt_q <= '0;
      else if (bit_inc) bit_cnt_q <= bit_cnt_q + 1'b1;
      if (fin) np_q <= miss;
      if (fin && !miss) begin
        fam_q <= rx_word[FAM_W-1:0];
        ser_q <= rx_word[FAM_W +: SER_W];
        chk_q <= rx_word[ROM_W-1 -: CHK_W];
      end
    end
  end

  assign bus_drive_low_o = drv_q;
  assign busy_o          = (state_q != ST_IDLE);
  assign done_o          = done_q;
  assign no_presence_o   = np_q;
  assign family_o        = fam_q;
  assign serial_o        = ser_q;
  assign check_o         = chk_q;

  // Checker state: length of the current low run on the drive pin.
  logic [RW-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               run_q <= '0;
    else if (!bus_drive_low_o) run_q <= '0;
    else if (run_q != '1)     run_q <= run_q + 1'b1;
  end

  a_r2_reset_len: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PRES_WAIT && $past(state_q) == ST_RST_LOW)
      |-> (run_q == RW'(T_RST_LOW_US * CLKS_PER_US)));
  a_r4_min_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_drive_low_o) |-> (run_q >= RW'(T_W1_LOW_US * CLKS_PER_US)));
  a_r2_drive_busy: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive_low_o |-> busy_o);
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  a_r7_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && !$past(cmd_shift)) |-> $stable(cmd_q));
  a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(done_o) && !done_o |-> ($stable(family_o) && $stable(serial_o) && $stable(check_o)));
endmodule

// File: tb/owire_rom_master_tb_top.sv
module owire_rom_master_tb_top;
  localparam int  K       = 1;
  localparam time CLK_PER = 10;
  localparam int  LIMIT   = 20000;

  logic clk = 1'b0;
  always #(CLK_PER/2) clk = ~clk;

  logic        rst_n = 1'b0, start_i = 1'b0;
  logic [7:0]  cmd_i = '0;
  logic        bus_line, drv, busy, done, np;
  logic [7:0]  fam, chk;
  logic [47:0] ser;

  logic        dev_pull = 1'b0, dev_present = 1'b1;
  logic [63:0] rom_word = '0;
  logic [7:0]  cmd_seen = '0;

  assign bus_line = !(drv || dev_pull);

  owire_rom_master #(.CLKS_PER_US(K)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i), .bus_in_i(bus_line),
    .bus_drive_low_o(drv), .busy_o(busy), .done_o(done), .no_presence_o(np),
    .family_o(fam), .serial_o(ser), .check_o(chk)
  );

  int nvec = 0, nfail = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Device model: answers the reset, reads the command at 37 us, drives read bits.
  always begin
    int len;
    @(posedge drv);
    len = 0;
    while (drv) begin @(negedge clk); len++; end
    if (len >= 480*K && dev_present) begin
      repeat (60*K) @(negedge clk);
      dev_pull = 1'b1;
      repeat (60*K) @(negedge clk);
      dev_pull = 1'b0;
      for (int i = 0; i < 8; i++) begin
        @(posedge drv);
        repeat (37*K) @(negedge clk);
        cmd_seen[i] = !drv;
      end
      for (int i = 0; i < 64; i++) begin
        @(posedge drv);
        @(negedge clk);
        dev_pull = !rom_word[i];
        repeat (14*K) @(negedge clk);
        dev_pull = 1'b0;
      end
    end
  end

  // Bus monitor sampled on the rising edge; cleared by the stimulus at falling edges.
  int cyc = 0, run = 0, rises = 0, last_rise = 0, min_gap = 0, odd_runs = 0;
  int rst_runs = 0, done_cnt = 0;
  logic drv_prev = 1'b0;
  always @(posedge clk) begin
    cyc++;
    if (drv) run++;
    else if (run > 0) begin
      if (run == 480*K) rst_runs++;
      else if (run != 2*K && run != 60*K) odd_runs++;
      run = 0;
    end
    if (drv && !drv_prev) begin
      rises++;
      if (rises >= 3 && (cyc - last_rise) < min_gap) min_gap = cyc - last_rise;
      last_rise = cyc;
    end
    drv_prev = drv;
    if (done) done_cnt++;
  end

  logic [7:0]  exp_fam = '0, exp_chk = '0;
  logic [47:0] exp_ser = '0;
  bit          timed_out = 1'b0;

  task automatic do_txn(input logic [7:0] c, input logic [63:0] w, input bit present,
                        input bit inject, input bit follow);
    int n;
    rom_word    = w;
    dev_present = present;
    cmd_i   = c;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cmd_i   = ~c;
    run = 0; rises = 0; min_gap = 1000000; odd_runs = 0; rst_runs = 0; done_cnt = 0;
    drv_prev = 1'b0;
    check(busy == 1'b1, "R2 busy after start", 64'(busy), 64'd1);
    check(fam == exp_fam && ser == exp_ser && chk == exp_chk, "R6 results held at start",
          {fam, ser, chk}, {exp_fam, exp_ser, exp_chk});
    n = 0;
    while (!done && n < LIMIT) begin
      @(negedge clk);
      n++;
      if (inject && (n == 100 || n == 2000) && !done) begin
        start_i = 1'b1; cmd_i = c ^ 8'h5A;
        @(negedge clk);
        n++;
        start_i = 1'b0;
      end
    end
    if (!done) begin
      check(1'b0, "R6 watchdog", 64'(n), 64'(LIMIT));
      timed_out = 1'b1;
      return;
    end
    check(busy == 1'b0, "R6 busy low with done", 64'(busy), 64'd0);
    check(np == !present, "R3 presence flag", 64'(np), 64'(!present));
    if (present) begin
      exp_fam = w[7:0]; exp_ser = w[55:8]; exp_chk = w[63:56];
      check(cmd_seen == c, "R4 command bits seen by device", 64'(cmd_seen), 64'(c));
      check(min_gap == 65*K, "R4 slot spacing", 64'(min_gap), 64'(65*K));
      check(rises == 2 + 8 + 64 - 1, "R5 slot count", 64'(rises), 64'd73);
    end else begin
      check(rises == 1, "R3 no slots without presence", 64'(rises), 64'd1);
    end
    check(fam == exp_fam, "R5 family field", 64'(fam), 64'(exp_fam));
    check(ser == exp_ser, "R5 serial field", 64'(ser), 64'(exp_ser));
    check(chk == exp_chk, "R5 check field", 64'(chk), 64'(exp_chk));
    check(rst_runs == 1 && odd_runs == 0, "R2 low pulse lengths",
          64'(odd_runs), 64'd0);
    if (follow) begin
      @(negedge clk);
      check(done == 1'b0 && busy == 1'b0, "R7 single done, no restart",
            {62'd0, done, busy}, 64'd0);
      check(done_cnt == 1, "R6 one done pulse", 64'(done_cnt), 64'd1);
    end
  endtask

  function automatic logic [63:0] rom_of(input int i);
    case (i)
      0: return 64'h0;
      1: return '1;
      2: return 64'h5555_5555_5555_5555;
      3: return (64'h1 << 37) | 64'h8000_0000_0000_0001;
      default: return (64'(i) * 64'h9E37_79B9_7F4A_7C15) ^ 64'hDEAD_BEEF_0123_4567;
    endcase
  endfunction

  function automatic logic [7:0] cmd_of(input int i);
    return (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'(i * 37 + 5);
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  initial begin
    #(CLK_PER * 200000);
    check(1'b0, "R6 global watchdog", 64'd0, 64'd1);
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check(busy == 1'b0, "R1 busy", 64'(busy), 64'd0);
    check(drv == 1'b0, "R1 bus released", 64'(drv), 64'd0);
    check(done == 1'b0, "R1 done", 64'(done), 64'd0);
    check(np == 1'b0, "R1 no_presence", 64'(np), 64'd0);
    check({fam, ser, chk} == 64'd0, "R1 results zero", {fam, ser, chk}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && drv == 1'b0, "R1 idle without start", {62'd0, busy, drv}, 64'd0);

    do_txn(8'h33, 64'h1234, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 6; i++) begin
      if (!timed_out) do_txn(cmd_of(i), rom_of(i), 1'b1, 1'b1, 1'b1);
    end
    if (!timed_out) do_txn(8'hC4, 64'h0F0F, 1'b0, 1'b0, 1'b1);
    // Completion and a new start in the same cycle.
    if (!timed_out) do_txn(8'h96, 64'hFEDC_BA98_7654_3210, 1'b1, 1'b0, 1'b0);
    if (!timed_out) do_txn(8'h69, 64'h0123_4567_89AB_CDEF, 1'b1, 1'b0, 1'b1);
    summary();
  end
endmodule